// File: doc/BRIEF.md
# Loadable Synchronous Binary Counter Stage with Carry-Out

This block is one stage of a binary up counter, four bits wide by default. The stage clears, loads and counts only on the rising clock edge. A clear forces the count to zero. A load copies a parallel data word into the count. While the enable is high and neither clear nor load is active, the count goes up by one. All state bits are updated together on the same edge.

The counting logic works bit by bit. Each bit flips when every bit below it is 1, so the next state of a bit is that bit XORed with the AND of all lower bits. The stage also drives a carry output, which is the AND of all state bits. This output lets stages be chained: a wider counter is built by feeding the lower stage's carry, ANDed with the shared enable, into the enable of the next stage up. The clear input also serves as the stage's reset.

Top module: `sync_count_stage`

## Requirements
- R1: When `clr` is high at a rising edge, `q` is all zeros after that edge, whatever the values of `ld`, `en` and `din`.
- R2: When `ld` is high and `clr` is low at a rising edge, `q` equals `din` after that edge, whether `en` is high or low. Bit `din[i]` goes to `q[i]`.
- R3: When `clr` and `ld` are low and `en` is high at a rising edge, `q` becomes the previous `q` plus one, modulo 2^WIDTH.
- R4: When `clr`, `ld` and `en` are all low at a rising edge, `q` keeps its value.
- R5: Counting from the all-ones value gives all zeros after the next edge.
- R6: `carry_out` is 1 exactly when `q` is all ones, whatever the value of `en`.
- R7: On a count edge, bit `q[i]` changes if and only if `q[0]` through `q[i-1]` were all 1. Bit `q[0]` therefore flips on every count edge.
- R8: In two stages chained as described, the upper stage advances exactly once for every 2^WIDTH counts of the lower stage. The step happens on the edge where the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high; highest priority; also the reset |
| ld | input | 1 | Synchronous parallel load, active high; second priority |
| en | input | 1 | Count enable, active high; lowest priority |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Registered count |
| carry_out | output | 1 | High when `q` is all ones |

## Verification
The bench targets these corner cases:

- **Clear with load and enable.** Clear is asserted in the same cycle as load and enable. A design with the wrong priority would show `din` or an incremented value instead of zero.
- **Load with enable low.** A load is applied while enable is low. A design that gates the load with the enable would keep the old count.
- **Wrap and carry.** The count passes through all ones. A broken carry chain would fail to wrap to zero, or would flip the wrong bits. The bench also checks that `carry_out` tracks the all-ones state when enable is low.
- **Two-stage chain.** A two-stage chain is run across several wraps. A carry that is late, early or ungated would make the upper stage step at the wrong edge or on every cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  function automatic cnt_op_e pick_op(input logic clr, input logic ld, input logic en);
    if (clr)      return OP_CLEAR;
    else if (ld)  return OP_LOAD;
    else if (en)  return OP_COUNT;
    else          return OP_HOLD;
  endfunction

endpackage

// File: rtl/cnt_op_dec.sv
module cnt_op_dec
  import cnt_pkg::*;
(
  input  logic    clr,
  input  logic    ld,
  input  logic    en,
  output cnt_op_e op
);
  always_comb op = pick_op(clr, ld, en);
endmodule

// File: rtl/cnt_carry_chain.sv
module cnt_carry_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] lower_all,
  output logic             all_ones
);
  assign lower_all[0] = 1'b1;

  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign lower_all[i] = lower_all[i-1] & q[i-1];
  end

  assign all_ones = lower_all[WIDTH-1] & q[WIDTH-1];
endmodule

// File: rtl/cnt_bit.sv
module cnt_bit
  import cnt_pkg::*;
(
  input  logic    clk,
  input  cnt_op_e op,
  input  logic    d_in,
  input  logic    lower_all,
  output logic    q_o
);
  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q_o <= 1'b0;
      OP_LOAD:  q_o <= d_in;
      OP_COUNT: q_o <= q_o ^ lower_all;
      default:  q_o <= q_o;
    endcase
  end
endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  cnt_op_e          op;
  logic [WIDTH-1:0] lower_all;

  cnt_op_dec u_dec (
    .clr (clr),
    .ld  (ld),
    .en  (en),
    .op  (op)
  );

  cnt_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .q         (q),
    .lower_all (lower_all),
    .all_ones  (carry_out)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    cnt_bit u_bit (
      .clk       (clk),
      .op        (op),
      .d_in      (din[i]),
      .lower_all (lower_all[i]),
      .q_o       (q[i])
    );
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) clr |=> q == ALL_ZERO);

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (clr)
    ld |=> q == $past(din));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!ld && en) |=> q == WIDTH'($past(q) + 1'b1));

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (clr)
    (!ld && !en) |=> $stable(q));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (clr)
    (!ld && en && carry_out) |=> q == ALL_ZERO);

  // R7
  lsb_flip_chk: assert property (@(posedge clk) disable iff (clr)
    (!ld && en) |=> q[0] != $past(q[0]));
endmodule

// File: tb/sim_sync_count_stage.sv
`timescale 1ns/1ps
module sim_sync_count_stage;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic clr = 1'b1, ld = 1'b0, en = 1'b0;
  logic [W-1:0] din_lo = '0, din_hi = '0;
  logic [W-1:0] q_lo, q_hi;
  logic co_lo, co_hi;
  logic en_hi;

  assign en_hi = en & co_lo;

  sync_count_stage #(.WIDTH(W)) u0 (
    .clk(clk), .clr(clr), .ld(ld), .en(en), .din(din_lo),
    .q(q_lo), .carry_out(co_lo));

  sync_count_stage #(.WIDTH(W)) u1 (
    .clk(clk), .clr(clr), .ld(ld), .en(en_hi), .din(din_hi),
    .q(q_hi), .carry_out(co_hi));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_lo = '0, m_hi = '0;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic c,
                                       input logic l, input logic e,
                                       input logic [W-1:0] d);
    if (c) return '0;
    if (l) return d;
    if (e) return W'(cur + 1);
    return cur;
  endfunction

  function automatic logic [W-1:0] flip_mask(input logic [W-1:0] cur);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      m[i] = 1'b1;
      for (int j = 0; j < i; j++) if (!cur[j]) m[i] = 1'b0;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic e,
                      input logic [W-1:0] dl, input logic [W-1:0] dh, input string tag);
    logic [W-1:0] prev;
    logic hi_en;
    @(negedge clk);
    clr = c; ld = l; en = e; din_lo = dl; din_hi = dh;
    prev = m_lo;
    hi_en = e && (m_lo == TOP);
    @(posedge clk);
    m_lo = nxt(m_lo, c, l, e, dl);
    m_hi = nxt(m_hi, c, l, hi_en, dh);
    #1;
    check(tag, q_lo, m_lo);
    check("R6", {{(W-1){1'b0}}, co_lo}, {{(W-1){1'b0}}, (m_lo == TOP)});
    check("R8", q_hi, m_hi);
    if (!c && !l && e) check("R7", q_lo ^ prev, flip_mask(prev));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    step(1, 0, 0, 4'h0, 4'h0, "R1");          // reset state
    step(0, 1, 1, 4'h9, 4'h3, "R2");
    step(1, 1, 1, 4'h7, 4'h5, "R1");          // clear beats load and enable
    step(0, 1, 0, 4'hE, 4'h2, "R2");          // load with enable low
    step(0, 0, 0, 4'h0, 4'h0, "R4");
    step(0, 0, 1, 4'h0, 4'h0, "R3");          // to 1111
    step(0, 0, 0, 4'h0, 4'h0, "R6");          // hold at all ones, carry high
    step(0, 0, 1, 4'h0, 4'h0, "R5");          // wrap, upper steps
    step(0, 1, 0, 4'h7, 4'h0, "R2");
    step(0, 0, 1, 4'h0, 4'h0, "R7");          // 0111 -> 1000
    step(1, 0, 0, 4'h0, 4'h0, "R1");
    for (int k = 0; k < 40; k++) step(0, 0, 1, 4'h0, 4'h0, "R3");
    check("R8", q_hi, 4'd2);                  // 40 counts -> two upper steps
    for (int k = 0; k < 300; k++) begin
      r = $urandom;
      step(r[3:0] == 4'h0, r[6:4] == 3'd0, r[8:7] != 2'd0,
           r[15:12], r[19:16], "R3");
    end
    finish_run();
  end
endmodule